// File: doc/BRIEF.md
# Multi-Lane Serial Memory Read Master

This block is the host side of a read path to a serial SRAM whose data pins form a shared 2-lane or 4-lane bidirectional bus. A start pulse supplies the lane mode, a 24-bit start address and a byte count. The master then lowers chip select and clocks the read opcode 03h followed by the address over the active lanes. It releases the lanes for one dummy byte and captures the requested bytes, each assembled from lane-wide slices with the high-order slice first. The bytes leave on a byte-wide valid/ready stream.

The serial clock idles low and is derived from the system clock by a parameterized divider. Outputs change on the falling serial-clock edge, and read data is sampled on the rising edge. When the consumer has not yet taken the previous byte, the serial clock is held low at the next byte boundary, so no byte is ever lost. After the last byte, chip select is raised and a one-cycle done pulse follows.

Top module: `mlane_read_master`

## Requirements
- R1: After reset, and whenever no transaction is running, cs_n_o is high, sck_o is low, lane_oe_o is 0, busy_o is low and byte_valid_o is low. sck_o is never high while cs_n_o is high.
- R2: A start_i pulse is taken only while busy_o is low and count_i is non-zero. A start with count 0, or any start while busy_o is high, has no effect: chip select does not toggle and the running transfer continues unchanged.
- R3: After cs_n_o falls, the master sends the byte 03h and then the 24-bit address, most significant bits first. In dual mode (quad_i=0) it sends 2 bits per serial clock on lanes 1:0, with lane 1 carrying the higher bit, over 16 clocks. In quad mode (quad_i=1) it sends 4 bits per clock on lanes 3:0, with lane 3 carrying the highest bit, over 8 clocks.
- R4: While cs_n_o is low, lane_o changes only on a falling serial-clock edge. It is stable at every rising edge and for as long as sck_o stays high.
- R5: During the opcode and address clocks, lane_oe_o is 4'b0011 in dual mode and 4'b1111 in quad mode. From the first dummy clock until cs_n_o rises, lane_oe_o is 0.
- R6: Exactly one dummy byte of serial clocks follows the address: 4 clocks in dual mode and 2 in quad mode. Lane input during these clocks is ignored.
- R7: Data is sampled from lane_i on rising serial-clock edges. A byte is built from slices 7:6, 5:4, 3:2, 1:0 in dual mode, and from slices 7:4, 3:0 in quad mode. Byte k of a transfer is the memory content at start address plus k.
- R8: Exactly count_i bytes are delivered. The transfer uses 16+4+4N serial clocks in dual mode and 8+2+2N in quad mode, then cs_n_o rises with sck_o low.
- R9: done_o is a single-cycle pulse in the first cycle after cs_n_o has been high for a full cycle. There is one pulse per accepted transfer.
- R10: While byte_valid_o is high and byte_ready_i is low, byte_valid_o and byte_o hold their values. The serial clock pauses at a byte boundary while the output holds an untaken byte, so every byte is delivered.
- R11: Each half period of sck_o lasts HALF_DIV system clock cycles when the output is not stalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request pulse for a read transfer |
| quad_i | input | 1 | Lane mode for the request: 0 selects 2 lanes, 1 selects 4 lanes |
| addr_i | input | 24 | Start address of the request |
| count_i | input | CNT_W | Number of bytes to read (0 is refused) |
| busy_o | output | 1 | A transfer is in progress |
| done_o | output | 1 | One-cycle pulse after chip select has risen |
| cs_n_o | output | 1 | Chip select, active low |
| sck_o | output | 1 | Serial clock, idles low |
| lane_o | output | 4 | Values driven onto the data lanes |
| lane_oe_o | output | 4 | Per-lane output enable |
| lane_i | input | 4 | Values read from the data lanes |
| byte_o | output | 8 | Received byte |
| byte_valid_o | output | 1 | byte_o holds a byte not yet taken |
| byte_ready_i | input | 1 | Consumer accepts byte_o |

## Verification
A corrupted phase counter moves the opcode or address bits or the start of data. This shows up at the first wrong serial clock, because the captured command or address no longer matches, or because every received byte becomes a shifted mix of two memory bytes. A wrong byte counter or lane-enable register shows up within one transfer, as a wrong total of serial clocks, a missing or extra byte, or lanes still driven during the dummy byte. A broken hold path shows up at the first stall of the slow consumer, as a byte that changes or vanishes while byte_valid_o is high.

// File: rtl/mlr_pkg.sv
package mlr_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_CMD,
        PH_DUMMY,
        PH_DATA,
        PH_TAIL,
        PH_FIN
    } phase_e;

    localparam logic [7:0] READ_OPCODE = 8'h03;
    localparam int         ADDR_W      = 24;
    localparam int         FRAME_W     = 8 + ADDR_W;

endpackage

// File: rtl/mlr_sck_divider.sv
module mlr_sck_divider #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic tick_o
);
    localparam int DW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [DW-1:0] LAST = DW'(HALF_DIV - 1);

    logic [DW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick_o = run_i && (cnt_q == LAST);
        if (!run_i || tick_o) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + DW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/mlr_tx_shifter.sv
module mlr_tx_shifter #(
    parameter int FRAME_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_i,
    input  logic [FRAME_W-1:0] frame_i,
    input  logic               shift_i,
    input  logic               quad_i,
    output logic [3:0]         lanes_o
);
    logic [FRAME_W-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (load_i) begin
            sh_d = frame_i;
        end else if (shift_i) begin
            sh_d = quad_i ? (sh_q << 4) : (sh_q << 2);
        end
        lanes_o = quad_i ? sh_q[FRAME_W-1 -: 4] : {2'b00, sh_q[FRAME_W-1 -: 2]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else begin
            sh_q <= sh_d;
        end
    end
endmodule

// File: rtl/mlr_rx_assembler.sv
module mlr_rx_assembler (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear_i,
    input  logic       sample_i,
    input  logic       quad_i,
    input  logic [3:0] lanes_i,
    output logic [7:0] byte_o
);
    logic [7:0] acc_d, acc_q;

    always_comb begin
        byte_o = quad_i ? {acc_q[3:0], lanes_i} : {acc_q[5:0], lanes_i[1:0]};
        acc_d  = acc_q;
        if (clear_i) begin
            acc_d = '0;
        end else if (sample_i) begin
            acc_d = byte_o;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc_d;
        end
    end
endmodule

// File: rtl/mlane_read_master.sv
module mlane_read_master
    import mlr_pkg::*;
#(
    parameter int HALF_DIV  = 2,
    parameter int MAX_BYTES = 256,
    localparam int CNT_W    = $clog2(MAX_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              quad_i,
    input  logic [23:0]       addr_i,
    input  logic [CNT_W-1:0]  count_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              cs_n_o,
    output logic              sck_o,
    output logic [3:0]        lane_o,
    output logic [3:0]        lane_oe_o,
    input  logic [3:0]        lane_i,
    output logic [7:0]        byte_o,
    output logic              byte_valid_o,
    input  logic              byte_ready_i
);
    localparam int CYC_W      = $clog2(FRAME_W / 2 + 1);
    localparam int CMD_DUAL   = FRAME_W / 2;
    localparam int CMD_QUAD   = FRAME_W / 4;
    localparam int DUMMY_DUAL = 4;
    localparam int DUMMY_QUAD = 2;
    localparam int SLICE_DUAL = 4;
    localparam int SLICE_QUAD = 2;

    typedef struct packed {
        phase_e             phase;
        logic               quad;
        logic               sck;
        logic               cs_n;
        logic [3:0]         oe;
        logic [CYC_W-1:0]   cyc;
        logic [CNT_W-1:0]   left;
        logic               out_valid;
        logic [7:0]         out_byte;
        logic               done;
    } state_t;

    state_t s_d, s_q;

    logic       tick;
    logic       run;
    logic       tx_load, tx_shift;
    logic       rx_clear, rx_sample;
    logic       push;
    logic [7:0] rx_byte;
    logic [CYC_W-1:0] slices;

    assign run = (s_q.phase == PH_CMD) || (s_q.phase == PH_DUMMY) ||
                 (s_q.phase == PH_DATA) || (s_q.phase == PH_TAIL);

    mlr_sck_divider #(.HALF_DIV(HALF_DIV)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (run),
        .tick_o (tick)
    );

    mlr_tx_shifter #(.FRAME_W(FRAME_W)) u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (tx_load),
        .frame_i ({READ_OPCODE, addr_i}),
        .shift_i (tx_shift),
        .quad_i  (s_q.quad),
        .lanes_o (lane_o)
    );

    mlr_rx_assembler u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (rx_clear),
        .sample_i (rx_sample),
        .quad_i   (s_q.quad),
        .lanes_i  (lane_i),
        .byte_o   (rx_byte)
    );

    always_comb begin
        s_d       = s_q;
        s_d.done  = 1'b0;
        tx_load   = 1'b0;
        tx_shift  = 1'b0;
        rx_clear  = 1'b0;
        rx_sample = 1'b0;
        push      = 1'b0;
        slices    = s_q.quad ? CYC_W'(SLICE_QUAD) : CYC_W'(SLICE_DUAL);

        if (s_q.out_valid && byte_ready_i) begin
            s_d.out_valid = 1'b0;
        end

        case (s_q.phase)
            PH_IDLE: begin
                if (start_i && (count_i != '0)) begin
                    s_d.phase = PH_CMD;
                    s_d.quad  = quad_i;
                    s_d.cs_n  = 1'b0;
                    s_d.oe    = quad_i ? 4'hF : 4'h3;
                    s_d.cyc   = quad_i ? CYC_W'(CMD_QUAD) : CYC_W'(CMD_DUAL);
                    s_d.left  = count_i;
                    tx_load   = 1'b1;
                    rx_clear  = 1'b1;
                end
            end
            PH_CMD, PH_DUMMY, PH_DATA: begin
                if (tick) begin
                    if (!s_q.sck) begin
                        // rising edge, unless a byte boundary must wait for the consumer
                        if (!((s_q.phase == PH_DATA) && (s_q.cyc == slices) && s_q.out_valid)) begin
                            s_d.sck = 1'b1;
                            if (s_q.phase == PH_DATA) begin
                                rx_sample = 1'b1;
                                if (s_q.cyc == CYC_W'(1)) begin
                                    push          = 1'b1;
                                    s_d.out_valid = 1'b1;
                                    s_d.out_byte  = rx_byte;
                                end
                            end
                        end
                    end else begin
                        // falling edge: advance the output and the phase counters
                        s_d.sck = 1'b0;
                        if (s_q.cyc != CYC_W'(1)) begin
                            s_d.cyc  = s_q.cyc - CYC_W'(1);
                            tx_shift = (s_q.phase == PH_CMD);
                        end else begin
                            case (s_q.phase)
                                PH_CMD: begin
                                    s_d.phase = PH_DUMMY;
                                    s_d.oe    = 4'h0;
                                    s_d.cyc   = s_q.quad ? CYC_W'(DUMMY_QUAD) : CYC_W'(DUMMY_DUAL);
                                end
                                PH_DUMMY: begin
                                    s_d.phase = PH_DATA;
                                    s_d.cyc   = slices;
                                end
                                default: begin
                                    s_d.cyc = slices;
                                    if (s_q.left == CNT_W'(1)) begin
                                        s_d.phase = PH_TAIL;
                                    end else begin
                                        s_d.left = s_q.left - CNT_W'(1);
                                    end
                                end
                            endcase
                        end
                    end
                end
            end
            PH_TAIL: begin
                if (tick) begin
                    s_d.cs_n  = 1'b1;
                    s_d.phase = PH_FIN;
                end
            end
            PH_FIN: begin
                s_d.done  = 1'b1;
                s_d.phase = PH_IDLE;
            end
            default: begin
                s_d.phase = PH_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q           <= '0;
            s_q.phase     <= PH_IDLE;
            s_q.cs_n      <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy_o       = (s_q.phase != PH_IDLE);
    assign done_o       = s_q.done;
    assign cs_n_o       = s_q.cs_n;
    assign sck_o        = s_q.sck;
    assign lane_oe_o    = s_q.oe;
    assign byte_o       = s_q.out_byte;
    assign byte_valid_o = s_q.out_valid;

    // R1: the serial clock only runs inside a chip-select window
    p_sck_inside_cs_r1: assert property (@(posedge clk) disable iff (!rst_n)
        sck_o |-> !cs_n_o);

    // R1: no lane is driven while deselected
    p_quiet_when_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_o |-> (lane_oe_o == 4'h0));

    // R2: a refused start leaves the bus deselected
    p_zero_count_refused_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i && (count_i == '0)) |=> (cs_n_o && !busy_o));

    // R2: a start during the command phase does not disturb chip select
    p_busy_start_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((s_q.phase == PH_CMD) && start_i) |=> !cs_n_o);

    // R4: lanes never move on a rising serial clock edge
    p_lane_stable_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n_o && $rose(sck_o)) |-> $stable(lane_o));

    // R5: lanes released from the dummy byte on
    p_released_after_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((s_q.phase == PH_DUMMY) || (s_q.phase == PH_DATA) || (s_q.phase == PH_TAIL))
            |-> (lane_oe_o == 4'h0));

    // R5: upper lanes are never enabled in dual mode
    p_dual_upper_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_q.quad) |-> (lane_oe_o[3:2] == 2'b00));

    // R9: done follows a full cycle of chip select high
    p_done_after_cs_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (cs_n_o && $past(cs_n_o)));

    // R10: an untaken byte holds still
    p_hold_byte_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid_o && !byte_ready_i) |=> (byte_valid_o && $stable(byte_o)));

    // R10: a new byte never lands on an occupied output
    p_no_overrun_r10: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !s_q.out_valid);

endmodule

// File: tb/mlane_read_master_test.sv
`timescale 1ns/1ps
module mlane_read_master_test;
    localparam int HD    = 2;
    localparam int MAXB  = 256;
    localparam int CNT_W = $clog2(MAXB + 1);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic             quad_i = 1'b0;
    logic [23:0]      addr_i = '0;
    logic [CNT_W-1:0] count_i = '0;
    logic             busy_o, done_o, cs_n_o, sck_o, byte_valid_o;
    logic [3:0]       lane_o, lane_oe_o;
    logic [3:0]       lane_i = 4'h0;
    logic [7:0]       byte_o;
    logic             byte_ready_i = 1'b1;

    mlane_read_master #(.HALF_DIV(HD), .MAX_BYTES(MAXB)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .quad_i(quad_i),
        .addr_i(addr_i), .count_i(count_i), .busy_o(busy_o), .done_o(done_o),
        .cs_n_o(cs_n_o), .sck_o(sck_o), .lane_o(lane_o), .lane_oe_o(lane_oe_o),
        .lane_i(lane_i), .byte_o(byte_o), .byte_valid_o(byte_valid_o),
        .byte_ready_i(byte_ready_i)
    );

    always #4 clk = ~clk;   // 125 MHz

    int checks = 0;
    int errors = 0;

    // memory contents seen by the slave model
    function automatic logic [7:0] mem_at(input logic [23:0] a);
        logic [7:0] m;
        m = a[7:0] * 8'd37;
        return m ^ a[15:8] ^ a[23:16] ^ 8'h6C;
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, what, act, act, exp, exp);
        end
    endtask

    // slave model and monitors, all in one process
    bit          tb_quad = 1'b0;
    bit          slow_ready = 1'b0;
    int          c_clk = 16, d_clk = 4, s_clk = 4;
    int          cyc = 0;
    int          rises = 0;
    logic [31:0] cap = '0;
    logic [7:0]  got [0:63];
    int          n_got = 0;
    int          cs_falls = 0, done_cnt = 0, done_bad = 0;
    int          oe_bad = 0, lane_bad = 0, hold_bad = 0;
    int          t_first = 0, t_second = 0;
    logic [3:0]  held_lane = '0;
    logic        prev_sck = 1'b0, prev_cs = 1'b1, prev_hold = 1'b0;
    logic [7:0]  prev_byte = '0;

    always @(posedge clk) begin
        cyc++;
        byte_ready_i <= slow_ready ? (cyc % 5 == 0) : 1'b1;
        if (prev_cs && !cs_n_o) begin
            rises = 0; cap = '0; n_got = 0; cs_falls++;
            lane_i <= 4'hF;
        end
        if (!prev_sck && sck_o) begin
            if (rises < c_clk) begin
                cap = tb_quad ? {cap[27:0], lane_o} : {cap[29:0], lane_o[1:0]};
                if (lane_oe_o !== (tb_quad ? 4'hF : 4'h3)) oe_bad++;
            end else if (lane_oe_o !== 4'h0) begin
                oe_bad++;
            end
            if (rises == 0) t_first = cyc;
            if (rises == 1) t_second = cyc;
            rises++;
            held_lane = lane_o;
        end else if (sck_o && !cs_n_o && lane_o !== held_lane) begin
            lane_bad++;
        end
        if (prev_sck && !sck_o && !cs_n_o && rises >= c_clk + d_clk) begin
            int k;
            int b;
            int s;
            logic [7:0] v;
            k = rises - (c_clk + d_clk);
            b = k / s_clk;
            s = k % s_clk;
            v = mem_at(cap[23:0] + 24'(b));
            if (tb_quad) lane_i <= 4'(v >> (4 * (s_clk - 1 - s)));
            else         lane_i <= {2'b00, 2'(v >> (2 * (s_clk - 1 - s)))};
        end
        if (byte_valid_o && byte_ready_i) begin
            if (n_got < 64) got[n_got] = byte_o;
            n_got++;
        end
        if (prev_hold && (byte_valid_o !== 1'b1 || byte_o !== prev_byte)) hold_bad++;
        prev_hold = byte_valid_o && !byte_ready_i;
        prev_byte = byte_o;
        if (done_o) begin
            done_cnt++;
            if (!(cs_n_o && prev_cs)) done_bad++;
        end
        prev_sck = sck_o;
        prev_cs  = cs_n_o;
    end

    task automatic run_read(input string name, input bit q, input logic [23:0] a,
                            input int n, input bit slow, input bit poke);
        int d0, f0, oe0, ln0, h0, db0, bad;
        tb_quad = q;
        c_clk = q ? 8 : 16;
        d_clk = q ? 2 : 4;
        s_clk = q ? 2 : 4;
        slow_ready = slow;
        d0 = done_cnt; f0 = cs_falls; oe0 = oe_bad; ln0 = lane_bad; h0 = hold_bad; db0 = done_bad;
        @(negedge clk);
        start_i = 1'b1; quad_i = q; addr_i = a; count_i = CNT_W'(n);
        @(negedge clk);
        start_i = 1'b0;
        if (poke) begin
            repeat (10) @(negedge clk);
            start_i = 1'b1; quad_i = ~q; addr_i = a ^ 24'h0F0F0F; count_i = CNT_W'(3);
            @(negedge clk);
            start_i = 1'b0;
        end
        for (int i = 0; i < 20000 && done_cnt == d0; i++) @(negedge clk);
        for (int i = 0; i < 2000 && n_got < n; i++) @(negedge clk);
        repeat (30) @(negedge clk);
        $display("-- %s", name);
        chk("R3", "opcode", int'(cap[31:24]), 3);
        chk("R3", "address", int'(cap[23:0]), int'(a));
        chk("R5", "lane enable errors", oe_bad - oe0, 0);
        chk("R4", "lane changes while clock high", lane_bad - ln0, 0);
        chk("R8", "bytes delivered", n_got, n);
        chk("R8", "serial clocks", rises, c_clk + d_clk + s_clk * n);
        bad = 0;
        for (int i = 0; i < n && i < 64; i++) begin
            if (got[i] !== mem_at(a + 24'(i))) begin
                bad++;
                $display("FAIL R7 byte %0d: actual 0x%0h expected 0x%0h", i, got[i], mem_at(a + 24'(i)));
            end
        end
        chk("R6/R7", "byte mismatches after dummy byte", bad, 0);
        chk("R9", "done pulses", done_cnt - d0, 1);
        chk("R9", "done before chip select settled", done_bad - db0, 0);
        chk("R10", "held byte disturbed", hold_bad - h0, 0);
        chk("R11", "serial clock period", t_second - t_first, 2 * HD);
        chk("R2", "chip select windows", cs_falls - f0, 1);
        chk("R1", "idle chip select", int'(cs_n_o), 1);
        chk("R1", "idle busy", int'(busy_o), 0);
    endtask

    task automatic test_reset();
        chk("R1", "reset cs_n_o", int'(cs_n_o), 1);
        chk("R1", "reset sck_o", int'(sck_o), 0);
        chk("R1", "reset lane_oe_o", int'(lane_oe_o), 0);
        chk("R1", "reset busy_o", int'(busy_o), 0);
        chk("R1", "reset byte_valid_o", int'(byte_valid_o), 0);
    endtask

    task automatic test_zero_count();
        int f0, d0, low;
        f0 = cs_falls; d0 = done_cnt; low = 0;
        @(negedge clk);
        start_i = 1'b1; quad_i = 1'b1; addr_i = 24'h000100; count_i = '0;
        @(negedge clk);
        start_i = 1'b0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (!cs_n_o || busy_o) low++;
        end
        chk("R2", "zero count activity", low, 0);
        chk("R2", "zero count windows", cs_falls - f0, 0);
        chk("R2", "zero count done", done_cnt - d0, 0);
    endtask

    bit finished = 1'b0;

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        run_read("dual, 3 bytes", 1'b0, 24'h012345, 3, 1'b0, 1'b0);
        run_read("quad, 5 bytes", 1'b1, 24'hABCDEF, 5, 1'b0, 1'b0);
        run_read("quad, slow consumer", 1'b1, 24'h00FFFC, 6, 1'b1, 1'b0);
        run_read("dual, slow consumer", 1'b0, 24'h7F0010, 5, 1'b1, 1'b0);
        test_zero_count();
        run_read("dual, start while busy", 1'b0, 24'h123456, 4, 1'b0, 1'b1);
        run_read("quad, single byte at top", 1'b1, 24'hFFFFFF, 1, 1'b0, 1'b0);
        run_read("dual, 20 bytes", 1'b0, 24'h3C0000, 20, 1'b0, 1'b0);
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule